// File: doc/BRIEF.md
# Channel Address and Data Jam Register

This block is the memory-side holding register that several peripheral channels share for direct memory transfers. A word register of `DW` bits is loaded in a single cycle, its whole content replaced, from one of three sources: the address lines of the channel being served, that channel's data lines, or the memory sense outputs. A separate `EW`-bit register holds the high-order extended address bits and has its own load strobe.

A load pulse is any one of a real grant, a simulated grant or a memory strobe. The served channel is the lowest-numbered channel whose data-select flag is set. A channel with its to-device flag clear is in an input transfer. Its first load pulse captures the channel address and its second captures the channel data word. A small two-state sequencer tracks which of the two comes next. A channel with its to-device flag set is in an output transfer. For that channel only the memory strobe loads the register, and it loads the sense bits; grants are ignored.

The sequencer has two states. `PH_ADDR` means the next input load takes the address. `PH_DATA` means the next input load takes the data word. There are four transitions:
- `PH_ADDR` to `PH_DATA` on an input-transfer load pulse (the address is captured).
- `PH_DATA` to `PH_ADDR` on an input-transfer load pulse (the data is captured).
- Any state to `PH_ADDR` when no data-select flag is set (abort).
- Any state to `PH_ADDR` on a memory strobe that serves an output transfer.

Top module: `chan_jam_reg`

## Requirements
- R1: While `rst_n` is low, `word_q` and `ext_q` are zero and the sequencer is in `PH_ADDR`.
- R2: In `PH_ADDR`, a load pulse for a served input-transfer channel `k` sets `word_q` to `ch_addr[k*AW +: AW]` in the low `AW` bits, with the upper `DW-AW` bits zero.
- R3: In `PH_DATA`, a load pulse for a served input-transfer channel `k` sets `word_q` to `ch_data[k*DW +: DW]`.
- R4: `grant`, `grant_sim` and `mem_strobe` each count as a load pulse for an input transfer. The register changes at the first rising clock edge at which the pulse is sampled high.
- R5: For a served channel with its `to_dev` bit set, `mem_strobe` sets `word_q` to `sense`.
- R6: For a served channel with its `to_dev` bit set, `grant` or `grant_sim` without `mem_strobe` leaves `word_q` unchanged.
- R7: With `set_data` all zero, no load pulse changes `word_q`.
- R8: When several `set_data` bits are set, the lowest index is served, with channel 0 the highest priority.
- R9: On `ext_load`, `ext_q` takes `ch_ext[k*EW +: EW]` of the lowest-indexed channel `k` whose `set_addr` bit is set. If no `set_addr` bit is set, `ext_q` becomes zero.
- R10: `ext_q` changes only on `ext_load`. Word loads and changes on `ch_ext` leave it unchanged.
- R11: A cycle with `set_data` all zero returns the sequencer to `PH_ADDR`, so the next input load captures an address.
- R12: Every load replaces all `DW` bits. No old bit survives, including when an address load follows a data load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power clear |
| grant | input | 1 | Real grant pulse |
| grant_sim | input | 1 | Simulated grant pulse |
| mem_strobe | input | 1 | Memory strobe pulse |
| ext_load | input | 1 | Extended-address load strobe |
| set_addr | input | NCH | Per-channel address-select flags |
| set_data | input | NCH | Per-channel data-select flags |
| to_dev | input | NCH | Per-channel direction, 1 = output transfer |
| ch_addr | input | NCH*AW | Channel address bits, channel k in slice k*AW |
| ch_ext | input | NCH*EW | Channel extended address bits, channel k in slice k*EW |
| ch_data | input | NCH*DW | Channel data words, channel k in slice k*DW |
| sense | input | DW | Memory sense outputs |
| word_q | output | DW | Word register contents |
| ext_q | output | EW | Extended address register contents |

## Verification
The bench builds the block with its defaults: three channels, an 18-bit word, a 13-bit address field and a 2-bit extended field. With three channels, a low-priority request can be overruled by channel 0 partway through a transfer. Each channel is given a distinct bit pattern, so a wrong source, a wrong channel or a lost address clear shows up as a value mismatch. Because the word is wider than the address field, the bench can see whether the upper bits are cleared when an address load follows a data load.

// File: rtl/chan_jam_pkg.sv
package chan_jam_pkg;
    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ADDR  = 2'd1,
        SRC_DATA  = 2'd2,
        SRC_SENSE = 2'd3
    } jam_src_t;
endpackage

// File: rtl/amx_pick.sv
module amx_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win,
    output logic         any
);
    logic seen;

    always_comb begin
        seen = 1'b0;
        for (int i = 0; i < N; i++) begin
            win[i] = req[i] && !seen;
            seen   = seen || req[i];
        end
        any = seen;
    end
endmodule

// File: rtl/amx_gather.sv
module amx_gather #(
    parameter int N = 3,
    parameter int W = 18
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] flat,
    output logic [W-1:0]   out
);
    logic [W-1:0] masked [N];

    for (genvar i = 0; i < N; i++) begin : g_mask
        assign masked[i] = flat[i*W +: W] & {W{sel[i]}};
    end

    always_comb begin
        out = '0;
        for (int i = 0; i < N; i++) begin
            out = out | masked[i];
        end
    end
endmodule

// File: rtl/chan_jam_reg.sv
module chan_jam_reg
    import chan_jam_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 18,
    parameter int AW  = 13,
    parameter int EW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic              grant_sim,
    input  logic              mem_strobe,
    input  logic              ext_load,
    input  logic [NCH-1:0]    set_addr,
    input  logic [NCH-1:0]    set_data,
    input  logic [NCH-1:0]    to_dev,
    input  logic [NCH*AW-1:0] ch_addr,
    input  logic [NCH*EW-1:0] ch_ext,
    input  logic [NCH*DW-1:0] ch_data,
    input  logic [DW-1:0]     sense,
    output logic [DW-1:0]     word_q,
    output logic [EW-1:0]     ext_q
);
    localparam int PADW = DW - AW;

    logic [NCH-1:0] dsel;
    logic [NCH-1:0] asel;
    logic           dany;
    logic           aany;
    logic [AW-1:0]  addr_mux;
    logic [DW-1:0]  data_mux;
    logic [EW-1:0]  ext_mux;
    logic           out_xfer;
    logic           load_pulse;
    phase_t         ph_q;
    phase_t         ph_d;
    jam_src_t       src;

    amx_pick #(.N(NCH)) u_dpick (.req(set_data), .win(dsel), .any(dany));
    amx_pick #(.N(NCH)) u_apick (.req(set_addr), .win(asel), .any(aany));

    amx_gather #(.N(NCH), .W(AW)) u_gaddr (.sel(dsel), .flat(ch_addr), .out(addr_mux));
    amx_gather #(.N(NCH), .W(DW)) u_gdata (.sel(dsel), .flat(ch_data), .out(data_mux));
    amx_gather #(.N(NCH), .W(EW)) u_gext  (.sel(asel), .flat(ch_ext),  .out(ext_mux));

    assign out_xfer   = dany && (|(dsel & to_dev));
    assign load_pulse = grant || grant_sim || mem_strobe;

    // next phase and load source
    always_comb begin
        ph_d = ph_q;
        src  = SRC_NONE;
        if (!dany) begin
            ph_d = PH_ADDR;
        end else if (out_xfer) begin
            if (mem_strobe) begin
                src  = SRC_SENSE;
                ph_d = PH_ADDR;
            end
        end else if (load_pulse) begin
            unique case (ph_q)
                PH_ADDR: begin
                    src  = SRC_ADDR;
                    ph_d = PH_DATA;
                end
                PH_DATA: begin
                    src  = SRC_DATA;
                    ph_d = PH_ADDR;
                end
            endcase
        end
    end

    // phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_ADDR;
        end else begin
            ph_q <= ph_d;
        end
    end

    // word register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            unique case (src)
                SRC_ADDR:  word_q <= {{PADW{1'b0}}, addr_mux};
                SRC_DATA:  word_q <= data_mux;
                SRC_SENSE: word_q <= sense;
                SRC_NONE:  word_q <= word_q;
            endcase
        end
    end

    // extended address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else if (ext_load) begin
            ext_q <= aany ? ext_mux : '0;
        end
    end
endmodule

// File: rtl/chan_jam_chk.sv
module chan_jam_chk #(
    parameter int NCH = 3,
    parameter int DW  = 18,
    parameter int EW  = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           grant,
    input logic           grant_sim,
    input logic           mem_strobe,
    input logic           ext_load,
    input logic [NCH-1:0] set_addr,
    input logic [NCH-1:0] set_data,
    input logic [NCH-1:0] to_dev,
    input logic [DW-1:0]  sense,
    input logic [DW-1:0]  word_q,
    input logic [EW-1:0]  ext_q
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (word_q == '0 && ext_q == '0)); // R1

    AST_OUT_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_data[0] && to_dev[0] && mem_strobe) |=> (word_q == $past(sense))); // R5

    AST_OUT_GRANT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (set_data[0] && to_dev[0] && !mem_strobe && (grant || grant_sim)) |=> $stable(word_q)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (set_data == '0) |=> $stable(word_q)); // R7

    AST_EXT_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_load && set_addr == '0) |=> (ext_q == '0)); // R9

    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_load |=> $stable(ext_q)); // R10
endmodule

bind chan_jam_reg chan_jam_chk #(.NCH(NCH), .DW(DW), .EW(EW)) u_chk (
    .clk(clk), .rst_n(rst_n), .grant(grant), .grant_sim(grant_sim),
    .mem_strobe(mem_strobe), .ext_load(ext_load), .set_addr(set_addr),
    .set_data(set_data), .to_dev(to_dev), .sense(sense),
    .word_q(word_q), .ext_q(ext_q)
);

// File: tb/sim_chan_jam_reg.sv
module sim_chan_jam_reg;
    localparam int NCH = 3;
    localparam int DW  = 18;
    localparam int AW  = 13;
    localparam int EW  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              grant = 1'b0;
    logic              grant_sim = 1'b0;
    logic              mem_strobe = 1'b0;
    logic              ext_load = 1'b0;
    logic [NCH-1:0]    set_addr = '0;
    logic [NCH-1:0]    set_data = '0;
    logic [NCH-1:0]    to_dev = '0;
    logic [NCH*AW-1:0] ch_addr;
    logic [NCH*EW-1:0] ch_ext;
    logic [NCH*DW-1:0] ch_data;
    logic [DW-1:0]     sense = 18'h0C3C3;
    logic [DW-1:0]     word_q;
    logic [EW-1:0]     ext_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [AW-1:0] A0 = 13'h0ABC, A1 = 13'h1234, A2 = 13'h0F0F;
    localparam logic [DW-1:0] D0 = 18'h2A5A5, D1 = 18'h15A5A, D2 = 18'h3FFFF;

    always #2 clk = ~clk;

    chan_jam_reg #(.NCH(NCH), .DW(DW), .AW(AW), .EW(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .grant(grant), .grant_sim(grant_sim),
        .mem_strobe(mem_strobe), .ext_load(ext_load), .set_addr(set_addr),
        .set_data(set_data), .to_dev(to_dev), .ch_addr(ch_addr),
        .ch_ext(ch_ext), .ch_data(ch_data), .sense(sense),
        .word_q(word_q), .ext_q(ext_q)
    );

    function automatic logic [DW-1:0] addr_word(input logic [AW-1:0] a);
        return {{(DW-AW){1'b0}}, a};
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0 grant, 1 grant_sim, 2 mem_strobe, 3 ext_load
    task automatic pulse(input int kind);
        @(negedge clk);
        case (kind)
            0: grant      = 1'b1;
            1: grant_sim  = 1'b1;
            2: mem_strobe = 1'b1;
            default: ext_load = 1'b1;
        endcase
        @(negedge clk);
        grant = 1'b0; grant_sim = 1'b0; mem_strobe = 1'b0; ext_load = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        set_data = '0; set_addr = '0; to_dev = '0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 word", word_q, '0);
        chk("R1 ext", {16'b0, ext_q}, '0);
        pulse(0);
        chk("R1 held in reset", word_q, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_input();
        set_data = 3'b001; to_dev = 3'b000;
        pulse(0);
        chk("R2 address jam", word_q, addr_word(A0));
        pulse(2);
        chk("R3 R4 data jam on strobe", word_q, D0);
        pulse(1);
        chk("R4 R12 address on simulated grant clears upper bits", word_q, addr_word(A0));
        pulse(0);
        chk("R3 data jam on grant", word_q, D0);
        idle();
    endtask

    task automatic t_output();
        set_data = 3'b010; to_dev = 3'b010;
        @(negedge clk);
        pulse(0);
        chk("R6 grant ignored", word_q, D0);
        pulse(1);
        chk("R6 simulated grant ignored", word_q, D0);
        pulse(2);
        chk("R5 sense jam", word_q, 18'h0C3C3);
        sense = 18'h30F0F;
        pulse(2);
        chk("R5 R12 second sense jam", word_q, 18'h30F0F);
        idle();
    endtask

    task automatic t_quiet();
        pulse(0);
        pulse(1);
        pulse(2);
        chk("R7 no channel served", word_q, 18'h30F0F);
    endtask

    task automatic t_priority();
        set_data = 3'b110;
        @(negedge clk);
        pulse(0);
        chk("R8 channel 1 over 2", word_q, addr_word(A1));
        set_data = 3'b111;
        pulse(2);
        chk("R8 channel 0 wins", word_q, D0);
        idle();
    endtask

    task automatic t_abort();
        set_data = 3'b100;
        @(negedge clk);
        pulse(0);
        chk("R2 channel 2 address", word_q, addr_word(A2));
        idle();
        set_data = 3'b001;
        pulse(0);
        chk("R11 abort returns to address", word_q, addr_word(A0));
        idle();
    endtask

    task automatic t_ext();
        set_addr = 3'b110;
        pulse(3);
        chk("R9 ext from channel 1", {16'b0, ext_q}, 18'd2);
        set_addr = 3'b000;
        pulse(3);
        chk("R9 ext zero when none", {16'b0, ext_q}, 18'd0);
        set_addr = 3'b100;
        pulse(3);
        chk("R9 ext from channel 2", {16'b0, ext_q}, 18'd3);
        set_addr = 3'b001; set_data = 3'b001;
        ch_ext = {2'b00, 2'b00, 2'b10};
        pulse(0);
        pulse(2);
        chk("R10 ext untouched by word loads", {16'b0, ext_q}, 18'd3);
        chk("R3 data after ext test", word_q, D0);
        idle();
    endtask

    initial begin
        ch_addr = {A2, A1, A0};
        ch_data = {D2, D1, D0};
        ch_ext  = {2'b11, 2'b10, 2'b01};
        @(negedge clk);
        t_reset();
        t_input();
        t_output();
        t_quiet();
        t_priority();
        t_abort();
        t_ext();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule